// File: doc/BRIEF.md
# Two-Wire Bus Write-Only Target Receiver

This block is the receive side of a target device on a two-wire serial bus. It watches an oversampled SCL/SDA pair, filters out short spikes, and recognises the bus framing conditions. After each START it collects an address byte. The block takes part in the transfer only when that byte holds its own seven-bit address with a write direction bit. It then acknowledges every byte it accepts and passes each data byte to downstream logic. START and STOP events are also given to downstream logic as single-cycle pulses, so that a register file behind the block can stage writes and commit them at the end of a transfer.

The seven-bit address always begins with the fixed pattern 0101 in its top four bits. A build parameter selects between two variants. In the eight-target variant the low three address bits come from strap pins. In the four-target variant the fifth bit is a fixed zero and only two strap pins set the low bits.

The data output is a valid/ready stream with a single holding register. A byte stays presented, and stable, until the consumer takes it with ready high. The bus cannot be stalled, because the block never stretches the clock. If the holding register is still full when the eighth bit of the next byte arrives, that byte is discarded and left unacknowledged. The block then ignores the bus until the next START or STOP. The consumer must therefore accept each byte within roughly one byte time.

Top module: `twowire_wr_target`

## Requirements
- R1: After reset, sda_oe, dat_valid, start_pulse and stop_pulse are all low.
- R2: start_pulse fires for one cycle when the filtered SDA falls while the filtered SCL is high. stop_pulse fires for one cycle when the filtered SDA rises while SCL is high. The two never fire together.
- R3: The block responds only to address bits [7:1] of the first byte equal to 0101 followed by the low bits. With FOUR_TGT=1 the low bits are a fixed 0 and then addr_pins[1:0]. With FOUR_TGT=0 they are addr_pins[2:0]. Bits are taken MSB first, one on each SCL rise.
- R4: An address byte whose bit 0 (the direction bit) is 1 is not acknowledged, even when bits [7:1] match.
- R5: For an accepted byte, sda_oe rises after the SCL fall that ends the eighth bit. It falls at the SCL fall that ends the ninth clock.
- R6: Every byte after a matching address is shifted in MSB first on SCL rises and is presented on dat_byte with dat_valid. While dat_valid is high and dat_ready is low, dat_valid and dat_byte hold their values. The address byte itself is never presented.
- R7: If dat_valid is still high and dat_ready low when the eighth bit of a data byte arrives, that byte is dropped and not acknowledged, and later bytes are ignored until the next START or STOP. The held byte is kept.
- R8: After an address mismatch, no following byte is acknowledged or presented until the next START or STOP.
- R9: A repeated START in the middle of a transfer restarts address reception and releases sda_oe.
- R10: A level change on SCL or SDA that lasts fewer than FILT_LEN system-clock samples is ignored. It causes no event and no extra bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 MHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line |
| addr_pins | input | PIN_W | Strap pins for the low address bits (2 when FOUR_TGT=1, else 3) |
| sda_oe | output | 1 | When high, the pad pulls SDA low (acknowledge) |
| dat_byte | output | 8 | Received data byte |
| dat_valid | output | 1 | dat_byte holds an unconsumed byte |
| dat_ready | input | 1 | Consumer accepts dat_byte this cycle |
| start_pulse | output | 1 | One-cycle pulse on START or repeated START |
| stop_pulse | output | 1 | One-cycle pulse on STOP |

## Verification
The hardest case to reach is the back-pressure drop. It needs a full holding register at the exact moment a following byte completes, so the bench holds dat_ready low across two data bytes. It then expects an acknowledge on the first byte, a missing acknowledge on the second and on a third, and the first byte still presented at the end. A repeated START after a rejected address, and spikes shorter than the filter length injected on an idle SDA and on SCL during the low phase of a transfer, are also driven directly by the bus-master tasks. These cases are checked through the event pulses and the value of the received byte.

// File: rtl/twt_pkg.sv
package twt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam logic [3:0] ADDR_PREFIX = 4'b0101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK_WAIT,
    ST_ACK_DRIVE,
    ST_SKIP
  } rx_state_t;
endpackage

// File: rtl/twt_line_filter.sv
module twt_line_filter #(
  parameter int FILT_LEN = 7,
  localparam int CW = $clog2(FILT_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_f
);
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  // two-stage synchroniser, idle level high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], line_i};
  end

  // a new level is taken only after it has stayed FILT_LEN samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_f <= 1'b1;
      cnt_q  <= '0;
    end else if (sync_q[1] != line_f) begin
      if (cnt_q == CW'(FILT_LEN - 1)) begin
        line_f <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/twt_bus_events.sv
module twt_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    start_evt = scl_q & scl_f & sda_q & ~sda_f;
    stop_evt  = scl_q & scl_f & ~sda_q & sda_f;
    scl_rise  = ~scl_q & scl_f;
    scl_fall  = scl_q & ~scl_f;
  end
endmodule

// File: rtl/twt_rx_ctrl.sv
module twt_rx_ctrl
  import twt_pkg::*;
#(
  parameter int FOUR_TGT = 1,
  localparam int PIN_W = (FOUR_TGT != 0) ? 2 : 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_W-1:0]  addr_pins,
  input  logic              sda_f,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              hold_free,
  output logic              load_req,
  output logic [BYTE_W-1:0] load_byte,
  output logic              sda_oe
);
  logic [ADDR_W-1:0] own_addr;
  rx_state_t         state_q;
  logic [2:0]        bit_q;
  logic [BYTE_W-2:0] shift_q;
  logic              last_bit;
  logic [BYTE_W-1:0] full_byte;
  logic              addr_hit;

  generate
    if (FOUR_TGT != 0) begin : g_four
      assign own_addr = {ADDR_PREFIX, 1'b0, addr_pins};
    end else begin : g_eight
      assign own_addr = {ADDR_PREFIX, addr_pins};
    end
  endgenerate

  always_comb begin
    full_byte = {shift_q, sda_f};
    last_bit  = scl_rise && (bit_q == 3'd7);
    addr_hit  = (full_byte[BYTE_W-1:1] == own_addr) && !full_byte[0];
    load_req  = (state_q == ST_DATA) && last_bit && hold_free;
    load_byte = full_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      shift_q <= '0;
      sda_oe  <= 1'b0;
    end else if (start_evt) begin
      state_q <= ST_ADDR;
      bit_q   <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_evt) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise) begin
            shift_q <= full_byte[BYTE_W-2:0];
            bit_q   <= bit_q + 1'b1;
          end
          if (last_bit) begin
            if (state_q == ST_ADDR)
              state_q <= addr_hit ? ST_ACK_WAIT : ST_SKIP;
            else
              state_q <= hold_free ? ST_ACK_WAIT : ST_SKIP;
          end
        end
        ST_ACK_WAIT: begin
          if (scl_fall) begin
            sda_oe  <= 1'b1;
            state_q <= ST_ACK_DRIVE;
          end
        end
        ST_ACK_DRIVE: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_q   <= '0;
            state_q <= ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twt_hold_reg.sv
module twt_hold_reg
  import twt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              dat_ready,
  output logic              hold_free,
  output logic [BYTE_W-1:0] dat_byte,
  output logic              dat_valid
);
  assign hold_free = !dat_valid || dat_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_valid <= 1'b0;
      dat_byte  <= '0;
    end else if (load_req) begin
      dat_valid <= 1'b1;
      dat_byte  <= load_byte;
    end else if (dat_ready) begin
      dat_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/twowire_wr_target.sv
module twowire_wr_target
  import twt_pkg::*;
#(
  parameter int FOUR_TGT = 1,
  parameter int FILT_LEN = 7,
  localparam int PIN_W = (FOUR_TGT != 0) ? 2 : 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [PIN_W-1:0]  addr_pins,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] dat_byte,
  output logic              dat_valid,
  input  logic              dat_ready,
  output logic              start_pulse,
  output logic              stop_pulse
);
  logic [1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic start_evt, stop_evt, scl_rise, scl_fall;
  logic hold_free, load_req;
  logic [BYTE_W-1:0] load_byte;

  assign raw_lines = {scl_i, sda_i};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_line
      twt_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (raw_lines[i]),
        .line_f (filt_lines[i])
      );
    end
  endgenerate

  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  twt_bus_events u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  twt_rx_ctrl #(.FOUR_TGT(FOUR_TGT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_pins (addr_pins),
    .sda_f     (sda_f),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .hold_free (hold_free),
    .load_req  (load_req),
    .load_byte (load_byte),
    .sda_oe    (sda_oe)
  );

  twt_hold_reg u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (load_req),
    .load_byte (load_byte),
    .dat_ready (dat_ready),
    .hold_free (hold_free),
    .dat_byte  (dat_byte),
    .dat_valid (dat_valid)
  );

  assign start_pulse = start_evt;
  assign stop_pulse  = stop_evt;
endmodule

// File: rtl/twt_checks.sv
module twt_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       dat_valid,
  input logic       dat_ready,
  input logic [7:0] dat_byte,
  input logic       start_pulse,
  input logic       stop_pulse,
  input logic       scl_fall
);
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && stop_pulse)); // R2
  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall)); // R5
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall || start_pulse || stop_pulse)); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && !dat_ready) |=> (dat_valid && $stable(dat_byte))); // R6
  AST_RESTART_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse || stop_pulse) |=> !sda_oe); // R9
endmodule

bind twowire_wr_target twt_checks u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .sda_oe      (sda_oe),
  .dat_valid   (dat_valid),
  .dat_ready   (dat_ready),
  .dat_byte    (dat_byte),
  .start_pulse (start_pulse),
  .stop_pulse  (stop_pulse),
  .scl_fall    (scl_fall)
);

// File: tb/twowire_wr_target_bench.sv
module twowire_wr_target_bench;
  localparam int H = 40;
  localparam logic [6:0] MY_ADDR = 7'h2A; // 0101 + 0 + pins 2'b10

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic dat_ready = 1'b0;
  logic [1:0] pins = 2'b10;
  logic sda_oe, dat_valid, start_pulse, stop_pulse;
  logic [7:0] dat_byte;
  logic sda_bus;
  int n_chk = 0, n_fail = 0;
  int n_start = 0, n_stop = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  twowire_wr_target u_twowire_wr_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_pins(pins), .sda_oe(sda_oe), .dat_byte(dat_byte),
    .dat_valid(dat_valid), .dat_ready(dat_ready),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && start_pulse) n_start <= n_start + 1;
    if (rst_n && stop_pulse)  n_stop  <= n_stop + 1;
    if (cyc == 150000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 150000)", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_restart();
    sda_m = 1'b1; wt(H / 2);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  // sends 8 bits MSB first plus ninth clock, returns acknowledge seen
  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      wt(H / 2); sda_m = b[i]; wt(H / 2);
      scl_m = 1'b1; wt(H);
      scl_m = 1'b0;
    end
    wt(H / 2); sda_m = 1'b1; wt(H / 2);
    scl_m = 1'b1; wt(H / 2);
    acked = (sda_bus == 1'b0);
    wt(H / 2);
    scl_m = 1'b0;
  endtask

  task automatic take_byte();
    dat_ready = 1'b1; wt(1); dat_ready = 1'b0; wt(1);
  endtask

  task automatic t_reset();
    chk(sda_oe == 0 && dat_valid == 0, "R1 oe/valid", {sda_oe, dat_valid}, 0);
    chk(n_start == 0 && n_stop == 0, "R1 pulses", n_start + n_stop, 0);
  endtask

  task automatic t_write();
    bit a; int s0, p0;
    s0 = n_start; p0 = n_stop;
    bus_start();
    chk(n_start == s0 + 1, "R2 start pulse", n_start - s0, 1);
    send_byte({MY_ADDR, 1'b0}, a);
    chk(a, "R3 address ack", a, 1);
    chk(dat_valid == 0, "R6 address not presented", dat_valid, 0);
    wt(H / 2);
    chk(sda_oe == 0, "R5 ack released after ninth clock", sda_oe, 0);
    send_byte(8'hA5, a);
    chk(a, "R5 data ack", a, 1);
    chk(dat_valid && dat_byte == 8'hA5, "R6 first byte", dat_byte, 8'hA5);
    take_byte();
    chk(dat_valid == 0, "R6 consumed", dat_valid, 0);
    send_byte(8'h3C, a);
    chk(a && dat_valid && dat_byte == 8'h3C, "R6 second byte", dat_byte, 8'h3C);
    take_byte();
    bus_stop();
    chk(n_stop == p0 + 1, "R2 stop pulse", n_stop - p0, 1);
  endtask

  task automatic t_fixed_zero();
    bit a;
    bus_start();
    send_byte({7'h2E, 1'b0}, a); // fifth bit set: not ours in four-target build
    chk(!a, "R3 fixed zero bit", a, 0);
    bus_stop();
  endtask

  task automatic t_read_dir();
    bit a;
    bus_start();
    send_byte({MY_ADDR, 1'b1}, a);
    chk(!a, "R4 read direction nack", a, 0);
    send_byte(8'h77, a);
    chk(!a && !dat_valid, "R4 following byte ignored", {a, dat_valid}, 0);
    bus_stop();
  endtask

  task automatic t_mismatch();
    bit a;
    bus_start();
    send_byte({7'h2B, 1'b0}, a);
    chk(!a, "R8 mismatch nack", a, 0);
    send_byte(8'h5A, a);
    chk(!a && !dat_valid, "R8 data ignored", {a, dat_valid}, 0);
    bus_stop();
  endtask

  task automatic t_restart();
    bit a; int s0;
    s0 = n_start;
    bus_start();
    send_byte({7'h2B, 1'b0}, a);
    bus_restart();
    chk(n_start == s0 + 2, "R9 repeated start pulse", n_start - s0, 2);
    send_byte({MY_ADDR, 1'b0}, a);
    chk(a, "R9 address after repeated start", a, 1);
    send_byte(8'h81, a);
    chk(a && dat_byte == 8'h81, "R9 data after repeated start", dat_byte, 8'h81);
    take_byte();
    bus_stop();
  endtask

  task automatic t_backpressure();
    bit a;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a);
    send_byte(8'h11, a);
    chk(a, "R7 first byte acked", a, 1);
    send_byte(8'h22, a);
    chk(!a, "R7 byte dropped nack", a, 0);
    chk(dat_valid && dat_byte == 8'h11, "R7 held byte kept", dat_byte, 8'h11);
    send_byte(8'h33, a);
    chk(!a && dat_byte == 8'h11, "R7 later bytes ignored", dat_byte, 8'h11);
    bus_stop();
    take_byte();
    chk(dat_valid == 0, "R7 drained", dat_valid, 0);
  endtask

  task automatic t_glitch();
    bit a; int s0, p0;
    s0 = n_start; p0 = n_stop;
    sda_m = 1'b0; wt(3); sda_m = 1'b1; wt(H);
    chk(n_start == s0 && n_stop == p0, "R10 sda spike no event", n_start - s0, 0);
    bus_start();
    send_byte({MY_ADDR, 1'b0}, a);
    wt(H / 4); scl_m = 1'b1; wt(3); scl_m = 1'b0; wt(H / 4);
    send_byte(8'hC3, a);
    chk(a && dat_byte == 8'hC3, "R10 scl spike no extra bit", dat_byte, 8'hC3);
    take_byte();
    bus_stop();
  endtask

  initial begin
    wt(5);
    t_reset();
    rst_n = 1'b1;
    wt(20);
    t_write();
    t_fixed_zero();
    t_read_dir();
    t_mismatch();
    t_restart();
    t_backpressure();
    t_glitch();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule